// File: doc/BRIEF.md
# Word and Byte Memory Port Controller

This block sits between a processor datapath and main memory and offers two independent ports. The word port holds a word address register and a word data register and moves whole 32-bit words. The register counts in words, and the memory address it drives is that count shifted left by two bits. The byte port holds the program counter, which counts in bytes, and an 8-bit instruction byte register that is filled by instruction fetches.

Each cycle the datapath gives a 3-bit memory operation code and may load any of the three programmable registers from the C bus. A request is latched at the clock edge that ends the issuing cycle. The memory sees it during the following cycle, and the returned value lands in the destination register at the end of that cycle. Until then the destination keeps its old contents. The B-bus output shows the word data register, the program counter, or the instruction byte widened to 32 bits with zeros or with its sign bit, as the source code selects.

Top module: `memport_ctrl`

## Requirements
- R1: While reset is held and right after its release, all registers and memory strobes are zero and the B bus reads zero for every source code.
- R2: The operation code has fetch in bit 0 (001), word read in bit 1 (010) and word write in bit 2 (100). Code 000 raises no strobe in the next cycle. Read and write together in one code are illegal.
- R3: A read issued in cycle t raises mem_rd in cycle t+1 with mem_addr equal to four times the word address register. The word data register keeps its old value through cycle t+1 and holds mem_rdata from cycle t+2. Bytes are little-endian: memory byte 4w is bits 7:0 of word w.
- R4: A write issued in cycle t raises mem_wr in cycle t+1 with mem_addr equal to four times the word address register and mem_wdata equal to the word data register as it stood in cycle t.
- R5: A fetch issued in cycle t raises fetch_en in cycle t+1 with fetch_addr equal to the program counter, unscaled. The instruction byte register keeps its old value through cycle t+1 and holds fetch_byte from cycle t+2.
- R6: A request uses register values from its issuing cycle. A load of the word address register or program counter in that same cycle does not change the request.
- R7: When a read lands in the same cycle as a C-bus load of the word data register, the memory value wins.
- R8: A write and a fetch issued together (code 101) are both carried out in the next cycle.
- R9: B-source codes: 0 gives the word data register, 1 gives the program counter, 2 gives the instruction byte zero-extended and 3 gives it sign-extended from bit 7.
- R10: With no load and no landing, the word data register, program counter and instruction byte register keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_op | input | 3 | Operation code: bit0 fetch, bit1 read, bit2 write |
| c_bus | input | DATA_W | Value for register loads |
| ld_addr | input | 1 | Load word address register from c_bus |
| ld_data | input | 1 | Load word data register from c_bus |
| ld_pc | input | 1 | Load program counter from c_bus |
| bsrc | input | 2 | B-bus source code |
| b_bus | output | DATA_W | Selected register value |
| mem_addr | output | AW | Byte address of the word access |
| mem_rd | output | 1 | Word read strobe |
| mem_wr | output | 1 | Word write strobe |
| mem_wdata | output | DATA_W | Word write data |
| mem_rdata | input | DATA_W | Word returned by memory |
| fetch_addr | output | AW | Byte address of the fetch |
| fetch_en | output | 1 | Fetch strobe |
| fetch_byte | input | 8 | Byte returned by memory |

## Verification
Word reads sweep every word address of a 64-byte memory filled with an arithmetic byte pattern. This separates correct scaling by four from unscaled or mis-shifted addresses, and it catches the wrong byte order. Fetches sweep every byte address, and the pattern contains bytes with bit 7 both set and clear, so zero and sign extension each give distinct results. Directed sequences cover the remaining cases: a load in the issuing cycle, a data load that collides with a landing read, a combined write and fetch, and write-then-readback of every word. They show whether requests capture their operands at the right edge, whether the memory value takes priority, and whether both ports can run at once.

// File: rtl/memport_pkg.sv
package memport_pkg;
   localparam int OP_FETCH_BIT = 0;
   localparam int OP_READ_BIT  = 1;
   localparam int OP_WRITE_BIT = 2;

   typedef enum logic [1:0] {
      BSRC_DATA   = 2'd0,
      BSRC_PC     = 2'd1,
      BSRC_BYTE_U = 2'd2,
      BSRC_BYTE_S = 2'd3
   } bsrc_e;
endpackage

// File: rtl/memport_word_port.sv
module memport_word_port #(
   parameter int DATA_W = 32,
   parameter int AW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_rd,
   input  logic              op_wr,
   input  logic [DATA_W-1:0] c_bus,
   input  logic [AW-1:0]     c_addr,
   input  logic              ld_addr,
   input  logic              ld_data,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [AW-1:0]     mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] data_q
);
   localparam int BYTES = DATA_W / 8;
   localparam int SHIFT = $clog2(BYTES);

   logic [AW-1:0]     waddr_q;
   logic [AW-1:0]     req_addr_q;
   logic [DATA_W-1:0] req_wdata_q;
   logic              rd_q, wr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         waddr_q     <= '0;
         data_q      <= '0;
         req_addr_q  <= '0;
         req_wdata_q <= '0;
         rd_q        <= 1'b0;
         wr_q        <= 1'b0;
      end else begin
         rd_q <= op_rd;
         wr_q <= op_wr;
         if (op_rd || op_wr)
            req_addr_q <= waddr_q << SHIFT;
         if (op_wr)
            req_wdata_q <= data_q;
         if (ld_addr)
            waddr_q <= c_addr;
         if (rd_q)
            data_q <= mem_rdata;
         else if (ld_data)
            data_q <= c_bus;
      end
   end

   assign mem_addr  = req_addr_q;
   assign mem_rd    = rd_q;
   assign mem_wr    = wr_q;
   assign mem_wdata = req_wdata_q;

   p_no_rd_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_rd && op_wr));
   p_rd_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      op_rd |=> (mem_rd && mem_addr == ($past(waddr_q) << SHIFT)));
   p_rd_land_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (data_q == $past(mem_rdata)));
   p_wr_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
      op_wr |=> (mem_wr && mem_wdata == $past(data_q)));
   p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rd && !ld_data) |=> $stable(data_q));
endmodule

// File: rtl/memport_byte_port.sv
module memport_byte_port #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_fetch,
   input  logic [AW-1:0] c_addr,
   input  logic          ld_pc,
   input  logic [7:0]    fetch_byte,
   output logic [AW-1:0] fetch_addr,
   output logic          fetch_en,
   output logic [AW-1:0] pc_q,
   output logic [7:0]    ibyte_q
);
   logic [AW-1:0] req_pc_q;
   logic          fe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q     <= '0;
         ibyte_q  <= '0;
         req_pc_q <= '0;
         fe_q     <= 1'b0;
      end else begin
         fe_q <= op_fetch;
         if (op_fetch)
            req_pc_q <= pc_q;
         if (ld_pc)
            pc_q <= c_addr;
         if (fe_q)
            ibyte_q <= fetch_byte;
      end
   end

   assign fetch_addr = req_pc_q;
   assign fetch_en   = fe_q;

   p_fetch_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
      op_fetch |=> (fetch_en && fetch_addr == $past(pc_q)));
   p_fetch_land_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_en |=> (ibyte_q == $past(fetch_byte)));
   p_byte_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_en |=> $stable(ibyte_q));
   p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_pc |=> $stable(pc_q));
endmodule

// File: rtl/memport_bmux.sv
module memport_bmux
   import memport_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int AW       = 32,
   parameter bit HAS_SEXT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bsrc,
   input  logic [DATA_W-1:0] data_q,
   input  logic [AW-1:0]     pc_q,
   input  logic [7:0]        ibyte_q,
   output logic [DATA_W-1:0] b_bus
);
   logic [DATA_W-1:0] byte_u, byte_s;
   bsrc_e             sel;

   assign sel    = bsrc_e'(bsrc);
   assign byte_u = DATA_W'(ibyte_q);

   generate
      if (HAS_SEXT) begin : g_sext
         assign byte_s = {{(DATA_W-8){ibyte_q[7]}}, ibyte_q};
      end else begin : g_zext_only
         assign byte_s = byte_u;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         BSRC_DATA:   b_bus = data_q;
         BSRC_PC:     b_bus = DATA_W'(pc_q);
         BSRC_BYTE_U: b_bus = byte_u;
         BSRC_BYTE_S: b_bus = byte_s;
         default:     b_bus = '0;
      endcase
   end

   p_zext_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == BSRC_BYTE_U) |-> (b_bus[DATA_W-1:8] == '0 && b_bus[7:0] == ibyte_q));
   p_sext_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == BSRC_BYTE_S && HAS_SEXT) |->
         (b_bus[7:0] == ibyte_q && $countones(b_bus[DATA_W-1:8]) == (ibyte_q[7] ? DATA_W-8 : 0)));
endmodule

// File: rtl/memport_ctrl.sv
module memport_ctrl
   import memport_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int AW       = 32,
   parameter bit HAS_SEXT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mem_op,
   input  logic [DATA_W-1:0] c_bus,
   input  logic              ld_addr,
   input  logic              ld_data,
   input  logic              ld_pc,
   input  logic [1:0]        bsrc,
   output logic [DATA_W-1:0] b_bus,
   output logic [AW-1:0]     mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [AW-1:0]     fetch_addr,
   output logic              fetch_en,
   input  logic [7:0]        fetch_byte
);
   localparam int SHIFT = $clog2(DATA_W / 8);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data_w
         $error("memport_ctrl: DATA_W must be a multiple of 8 and at least 16");
      end
      if (AW > DATA_W || AW <= SHIFT) begin : g_bad_aw
         $error("memport_ctrl: AW must exceed the byte shift and fit in DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] data_q;
   logic [AW-1:0]     pc_q;
   logic [7:0]        ibyte_q;
   logic [AW-1:0]     c_addr;

   assign c_addr = c_bus[AW-1:0];

   memport_word_port #(.DATA_W(DATA_W), .AW(AW)) u_word (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_rd     (mem_op[OP_READ_BIT]),
      .op_wr     (mem_op[OP_WRITE_BIT]),
      .c_bus     (c_bus),
      .c_addr    (c_addr),
      .ld_addr   (ld_addr),
      .ld_data   (ld_data),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .data_q    (data_q)
   );

   memport_byte_port #(.AW(AW)) u_byte (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_fetch   (mem_op[OP_FETCH_BIT]),
      .c_addr     (c_addr),
      .ld_pc      (ld_pc),
      .fetch_byte (fetch_byte),
      .fetch_addr (fetch_addr),
      .fetch_en   (fetch_en),
      .pc_q       (pc_q),
      .ibyte_q    (ibyte_q)
   );

   memport_bmux #(.DATA_W(DATA_W), .AW(AW), .HAS_SEXT(HAS_SEXT)) u_bmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .bsrc    (bsrc),
      .data_q  (data_q),
      .pc_q    (pc_q),
      .ibyte_q (ibyte_q),
      .b_bus   (b_bus)
   );

   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_op == 3'b000) |=> (!mem_rd && !mem_wr && !fetch_en));
   p_wr_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_op == 3'b101) |=> (mem_wr && fetch_en && !mem_rd));
endmodule

// File: tb/memport_ctrl_bench.sv
module memport_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  mem_op;
   logic [31:0] c_bus;
   logic        ld_addr, ld_data, ld_pc;
   logic [1:0]  bsrc;
   logic [31:0] b_bus, mem_addr, mem_wdata, mem_rdata, fetch_addr;
   logic        mem_rd, mem_wr, fetch_en;
   logic [7:0]  fetch_byte;
   logic [7:0]  mem [64];
   int          vectors = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   memport_ctrl u_memport_ctrl (
      .clk(clk), .rst_n(rst_n), .mem_op(mem_op), .c_bus(c_bus),
      .ld_addr(ld_addr), .ld_data(ld_data), .ld_pc(ld_pc), .bsrc(bsrc),
      .b_bus(b_bus), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .fetch_addr(fetch_addr),
      .fetch_en(fetch_en), .fetch_byte(fetch_byte)
   );

   function automatic logic [7:0] pat(int i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   function automatic logic [31:0] pword(int w);
      return {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= pat(i);
      end else if (mem_wr) begin
         for (int k = 0; k < 4; k++)
            mem[(mem_addr[5:0] & 6'h3c) + 6'(k)] <= mem_wdata[8*k +: 8];
      end
   end

   always_comb begin
      mem_rdata = {mem[(mem_addr[5:0] & 6'h3c) + 6'd3], mem[(mem_addr[5:0] & 6'h3c) + 6'd2],
                   mem[(mem_addr[5:0] & 6'h3c) + 6'd1], mem[mem_addr[5:0] & 6'h3c]};
      fetch_byte = mem[fetch_addr[5:0]];
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      #1;
      mem_op = 3'b000; ld_addr = 1'b0; ld_data = 1'b0; ld_pc = 1'b0;
   endtask

   task automatic bus(logic [1:0] s, output logic [31:0] v);
      bsrc = s;
      #1;
      v = b_bus;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [31:0] v, prev;
      rst_n = 1'b0; mem_op = 3'b000; c_bus = '0;
      ld_addr = 1'b0; ld_data = 1'b0; ld_pc = 1'b0; bsrc = 2'd0;
      repeat (3) cyc();
      // R1 reset state
      for (int s = 0; s < 4; s++) begin
         bus(2'(s), v); chk("R1 b_bus", v, 32'h0);
      end
      chk("R1 strobes", {29'h0, mem_rd, mem_wr, fetch_en}, 32'h0);
      chk("R1 mem_addr", mem_addr, 32'h0);
      chk("R1 fetch_addr", fetch_addr, 32'h0);
      rst_n = 1'b1;
      cyc();
      // R2 idle code
      mem_op = 3'b000; cyc();
      chk("R2 idle strobes", {29'h0, mem_rd, mem_wr, fetch_en}, 32'h0);

      // R3 read sweep
      prev = 32'h0;
      for (int w = 0; w < 16; w++) begin
         c_bus = 32'(w); ld_addr = 1'b1; cyc();
         mem_op = 3'b010; cyc();
         chk("R2 read strobes", {29'h0, mem_rd, mem_wr, fetch_en}, 32'h4);
         chk("R3 scaled addr", mem_addr, 32'(4*w));
         bus(2'd0, v); chk("R3 old data held", v, prev);
         cyc();
         bus(2'd0, v); chk("R3 read data", v, pword(w));
         prev = v;
      end

      // R5 and R9 fetch sweep
      for (int p = 0; p < 64; p++) begin
         logic [7:0] old;
         old = (p == 0) ? 8'h00 : pat(p-1);
         c_bus = 32'(p); ld_pc = 1'b1; cyc();
         mem_op = 3'b001; cyc();
         chk("R2 fetch strobes", {29'h0, mem_rd, mem_wr, fetch_en}, 32'h1);
         chk("R5 byte addr", fetch_addr, 32'(p));
         bus(2'd2, v); chk("R5 old byte held", v, {24'h0, old});
         cyc();
         bus(2'd2, v); chk("R9 zero ext", v, {24'h0, pat(p)});
         bus(2'd3, v); chk("R9 sign ext", v, {{24{pat(p)[7]}}, pat(p)});
         bus(2'd1, v); chk("R9 pc source", v, 32'(p));
      end

      // R6 capture at issue
      c_bus = 32'd5; ld_addr = 1'b1; cyc();
      c_bus = 32'd9; ld_addr = 1'b1; mem_op = 3'b010; cyc();
      chk("R6 word addr from issue cycle", mem_addr, 32'd20);
      cyc();
      bus(2'd0, v); chk("R6 read of old address", v, pword(5));
      c_bus = 32'd7; ld_pc = 1'b1; cyc();
      c_bus = 32'd50; ld_pc = 1'b1; mem_op = 3'b001; cyc();
      chk("R6 fetch addr from issue cycle", fetch_addr, 32'd7);
      cyc();
      bus(2'd2, v); chk("R6 fetched byte", v, {24'h0, pat(7)});
      bus(2'd1, v); chk("R6 pc loaded", v, 32'd50);

      // R7 landing beats C-bus load (word address now 9)
      mem_op = 3'b010; cyc();
      c_bus = 32'hDEADBEEF; ld_data = 1'b1; cyc();
      bus(2'd0, v); chk("R7 memory wins", v, pword(9));

      // R8 write and fetch together
      c_bus = 32'd3; ld_addr = 1'b1; cyc();
      c_bus = 32'h1234_5678; ld_data = 1'b1; cyc();
      c_bus = 32'd40; ld_pc = 1'b1; cyc();
      mem_op = 3'b101; cyc();
      chk("R8 both strobes", {29'h0, mem_rd, mem_wr, fetch_en}, 32'h3);
      chk("R8 write addr", mem_addr, 32'd12);
      cyc();
      bus(2'd2, v); chk("R8 fetched byte", v, {24'h0, pat(40)});
      mem_op = 3'b010; cyc(); cyc();
      bus(2'd0, v); chk("R8 written word", v, 32'h1234_5678);

      // R4 write sweep with readback
      for (int w = 0; w < 16; w++) begin
         logic [31:0] d;
         d = 32'hA55A_0000 ^ (32'(w) * 32'h0101_0101);
         c_bus = 32'(w); ld_addr = 1'b1; cyc();
         c_bus = d; ld_data = 1'b1; cyc();
         c_bus = 32'hFFFF_FFFF; ld_data = 1'b1; mem_op = 3'b100; cyc();
         chk("R4 write strobe", {31'h0, mem_wr}, 32'h1);
         chk("R4 write addr", mem_addr, 32'(4*w));
         chk("R4 write data from issue cycle", mem_wdata, d);
         cyc();
         mem_op = 3'b010; cyc(); cyc();
         bus(2'd0, v); chk("R4 readback", v, d);
         c_bus = 32'(4*w+1); ld_pc = 1'b1; cyc();
         mem_op = 3'b001; cyc(); cyc();
         bus(2'd2, v); chk("R4 byte order", v, {24'h0, d[15:8]});
      end

      // R10 hold while idle
      bus(2'd0, prev);
      repeat (5) cyc();
      bus(2'd0, v); chk("R10 data hold", v, prev);
      bus(2'd1, v); chk("R10 pc hold", v, 32'd61);
      bus(2'd2, v); chk("R10 byte hold", v, {24'h0, prev[15:8]});
      summary();
   end
endmodule